// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port Controller

This block moves one 8-bit frame at a time over a four-wire synchronous serial link, either as the clock-owning master or as a selected slave. Software sets it up through one control byte. That byte turns the port on, picks the role, the idle clock level, the sampling phase and the master bit rate, and chooses open-drain or push-pull pad drive. A status byte reports frame completion and mode faults, and a data byte sends and receives frames. An interrupt request is raised from the two flags when the control byte allows it and the chip-level interrupt mask input is clear.

The pad side gives a drive value and an output enable for the clock, master-out and master-in pins. It also tells the port logic when the four pins belong to the serial function, and when the select pin has been handed back to general-purpose output in master mode. A master shifts the most significant bit first and generates eight clock cycles per frame. A slave follows the incoming clock while its select input is low.

Top module: `spi_port_ctrl`

## Requirements
- R1: The control byte (address 0) holds, from bit 7 down to bit 0: interrupt enable, port enable, open-drain select, master select, clock polarity, clock phase, rate bit 1, rate bit 0. It resets to 0x24. The status byte (address 1) shows the frame-complete flag in bit 7 and the mode-fault flag in bit 6, and reads 0x00 after reset. reg_rdata always shows the register selected by reg_addr.
- R2: Writing the data byte (address 2) while the block is an idle master sends that byte MSB first over exactly 8 clock cycles. The byte sampled from the master-in pin then reads back at address 2.
- R3: The master half clock period is 1, 2, 8 or 16 bus clocks for rate codes 0, 1, 2 and 3. The frame-complete flag reads 0 up to 16×half−1 cycles after the write edge and reads 1 from 16×half cycles after it.
- R4: The master clock pin rests at the clock polarity level (0 or 1) whenever no frame is in progress.
- R5: With phase 0, the MSB is on the master-out pin as soon as the data byte is written, and bits are sampled on leading clock edges. With phase 1, the master-out pin reads 0 until the first clock edge puts the MSB out, and bits are sampled on trailing edges.
- R6: As a slave with select low, the block shifts out the byte last written to address 2 on the master-in pin. It receives the master-out bits and sets the frame-complete flag after the eighth trailing edge.
- R7: The frame-complete flag clears only when a status read with the flag set is followed by a read or write of address 2. A data access without that status read leaves the flag set.
- R8: irq_o is 1 while either flag is set, the interrupt enable bit is 1 and irq_mask_i is 0. Otherwise it is 0.
- R9: With the port enable bit 0, all three output enables and pins_spi_o are 0.
- R10: An enabled master with ss_dir_i = 1 sets ss_gp_o = 1 and ignores the select input, so a low select sets no fault.
- R11: An enabled master with ss_dir_i = 0 that sees select low sets the fault flag, clears the master bit and drops all output enables. A status read with the fault flag set, followed by a control write, clears the flag.
- R12: With the open-drain bit 1, a serial output that should be high has its enable at 0, and a driven output is always low. With the bit at 0, the enable follows the role and the value is driven directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the clearing sequences) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks the request |
| irq_o | output | 1 | Interrupt request |
| ss_dir_i | input | 1 | Port direction bit of the select pin |
| ss_n_i | input | 1 | Select pin input, active low |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock drive value |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out pin input (slave data in) |
| mosi_o | output | 1 | Master-out drive value |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in pin input (master data in) |
| miso_o | output | 1 | Master-in drive value |
| miso_oe | output | 1 | Master-in output enable |
| pins_spi_o | output | 1 | The four pins are owned by the serial function |
| ss_gp_o | output | 1 | Select pin handed back to general-purpose output |

## Verification
A master frame started by a data write at clock edge E0 produces clock edges at E0 + k×half. The flag is visible after E0 + 16×half, so the bench reads the status one cycle before and at that cycle, always at the falling clock edge. The select and clock inputs pass through two synchronizer stages. A fault therefore appears three edges after select falls, and slave shifts lag the bench's clock edges by three cycles. The bench waits four cycles before fault checks and holds each slave half clock period for eight cycles. The serial monitor takes master-out bits at the negedge after each observed clock-pin change and compares each completed byte with the queue the driver filled.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MXFER = 2'd1,
        ST_SXFER = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic       irq_en;
        logic       spi_en;
        logic       wired_or;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam logic [7:0] CTRL_RST  = 8'h24;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam int unsigned DIV_W    = 5;

    function automatic logic [DIV_W-1:0] half_period(input logic [1:0] code);
        logic [DIV_W-1:0] h;
        unique case (code)
            2'd0:    h = DIV_W'(1);
            2'd1:    h = DIV_W'(2);
            2'd2:    h = DIV_W'(8);
            default: h = DIV_W'(16);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && (cnt == half - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         lead,
    input  logic         trail,
    input  logic         cpha,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] rx_word,
    output logic         frame_done
);
    localparam int unsigned CNT_W = $clog2(W);

    logic [W-1:0]     shreg;
    logic             latch_bit;
    logic             out_bit;
    logic [CNT_W-1:0] bitcnt;

    assign sout       = cpha ? out_bit : shreg[W-1];
    assign rx_word    = {shreg[W-2:0], (cpha ? sin : latch_bit)};
    assign frame_done = trail && (bitcnt == CNT_W'(W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            latch_bit <= 1'b0;
            out_bit   <= 1'b0;
            bitcnt    <= '0;
        end else if (clr) begin
            latch_bit <= 1'b0;
            out_bit   <= 1'b0;
            bitcnt    <= '0;
            if (load) begin
                shreg <= load_data;
            end
        end else begin
            if (lead) begin
                if (cpha) begin
                    out_bit <= shreg[W-1];
                end else begin
                    latch_bit <= sin;
                end
            end
            if (trail) begin
                shreg  <= rx_word;
                bitcnt <= bitcnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        m_mode,
    input  logic        s_sel,
    input  logic        start,
    input  logic        m_tick,
    input  logic        frame_done,
    input  logic        slave_sck,
    output xfer_state_t state,
    output logic        lead,
    output logic        trail,
    output logic        shift_clr,
    output logic        sck_lvl
);
    xfer_state_t state_nx;
    logic        s_prev;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (m_mode && start) begin
                    state_nx = ST_MXFER;
                end else if (s_sel) begin
                    state_nx = ST_SXFER;
                end
            end
            ST_MXFER: begin
                if (!m_mode || frame_done) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SXFER: begin
                if (!s_sel) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sck_lvl <= 1'b0;
            s_prev  <= 1'b0;
        end else begin
            state  <= state_nx;
            s_prev <= slave_sck;
            if (state != ST_MXFER) begin
                sck_lvl <= 1'b0;
            end else if (m_tick) begin
                sck_lvl <= ~sck_lvl;
            end
        end
    end

    always_comb begin
        lead      = 1'b0;
        trail     = 1'b0;
        shift_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                shift_clr = 1'b1;
            end
            ST_MXFER: begin
                lead  = m_tick && !sck_lvl;
                trail = m_tick && sck_lvl;
            end
            ST_SXFER: begin
                lead  = slave_sck && !s_prev;
                trail = !slave_sck && s_prev;
            end
            default: shift_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int unsigned FRAME_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_mask_i,
    output logic       irq_o,
    input  logic       ss_dir_i,
    input  logic       ss_n_i,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    output logic       pins_spi_o,
    output logic       ss_gp_o
);
    localparam int unsigned N_PINS = 3;

    ctrl_t               ctrl;
    logic                done_flag, fault_flag, done_arm, fault_arm;
    logic [FRAME_W-1:0]  rx_buf;
    logic [SYNC_STAGES-1:0] ss_q, sck_q;
    logic                ss_s, sck_s;
    logic                m_mode, s_sel, fault_det;
    logic                ctrl_wr, stat_rd, data_wr, data_acc, load;
    xfer_state_t         state;
    logic                lead, trail, shift_clr, sck_lvl, m_tick;
    logic                sout, frame_done;
    logic [FRAME_W-1:0]  rx_word;
    logic [N_PINS-1:0]   pin_en, pin_raw, pin_o, pin_oe;

    // input synchronizers for the asynchronous pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q  <= '1;
            sck_q <= '0;
        end else begin
            ss_q  <= {ss_q[SYNC_STAGES-2:0], ss_n_i};
            sck_q <= {sck_q[SYNC_STAGES-2:0], sck_i};
        end
    end
    assign ss_s  = ss_q[SYNC_STAGES-1];
    assign sck_s = sck_q[SYNC_STAGES-1];

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_rd   = reg_rd && (reg_addr == ADDR_STAT);
    assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
    assign data_acc  = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
    assign load      = data_wr && (state == ST_IDLE);

    assign m_mode    = ctrl.spi_en && ctrl.master && !fault_flag;
    assign s_sel     = ctrl.spi_en && !ctrl.master && !ss_s && !fault_flag;
    assign fault_det = ctrl.spi_en && ctrl.master && !ss_dir_i && !ss_s;
    assign ss_gp_o   = ctrl.spi_en && ctrl.master && ss_dir_i;
    assign pins_spi_o = ctrl.spi_en;

    spi_rate_div #(.CW(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_MXFER),
        .half (half_period(ctrl.rate)),
        .tick (m_tick)
    );

    spi_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_mode    (m_mode),
        .s_sel     (s_sel),
        .start     (data_wr),
        .m_tick    (m_tick),
        .frame_done(frame_done),
        .slave_sck (sck_s ^ ctrl.cpol),
        .state     (state),
        .lead      (lead),
        .trail     (trail),
        .shift_clr (shift_clr),
        .sck_lvl   (sck_lvl)
    );

    spi_shifter #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (shift_clr),
        .load      (load),
        .load_data (FRAME_W'(reg_wdata)),
        .lead      (lead),
        .trail     (trail),
        .cpha      (ctrl.cpha),
        .sin       (ctrl.master ? miso_i : mosi_i),
        .sout      (sout),
        .rx_word   (rx_word),
        .frame_done(frame_done)
    );

    // registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= ctrl_t'(CTRL_RST);
            done_flag  <= 1'b0;
            fault_flag <= 1'b0;
            done_arm   <= 1'b0;
            fault_arm  <= 1'b0;
            rx_buf     <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl <= ctrl_t'(reg_wdata);
            end
            if (fault_det) begin
                ctrl.master <= 1'b0;
            end

            if (frame_done) begin
                rx_buf <= rx_word;
            end

            if (frame_done) begin
                done_flag <= 1'b1;
            end else if (done_arm && data_acc) begin
                done_flag <= 1'b0;
            end
            if (stat_rd && done_flag) begin
                done_arm <= 1'b1;
            end else if (data_acc) begin
                done_arm <= 1'b0;
            end

            if (fault_det) begin
                fault_flag <= 1'b1;
            end else if (fault_arm && ctrl_wr) begin
                fault_flag <= 1'b0;
            end
            if (stat_rd && fault_flag) begin
                fault_arm <= 1'b1;
            end else if (ctrl_wr) begin
                fault_arm <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl;
            ADDR_STAT: reg_rdata = {done_flag, fault_flag, 6'b0};
            ADDR_DATA: reg_rdata = 8'(rx_buf);
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign irq_o = ctrl.irq_en && !irq_mask_i && (done_flag || fault_flag);

    // pad drivers: index 0 clock, 1 master-out, 2 master-in
    assign pin_en  = {s_sel, m_mode, m_mode};
    assign pin_raw = {sout, sout, sck_lvl ^ ctrl.cpol};

    for (genvar p = 0; p < N_PINS; p++) begin : g_pad
        assign pin_oe[p] = pin_en[p] && (!ctrl.wired_or || !pin_raw[p]);
        assign pin_o[p]  = pin_raw[p] && !ctrl.wired_or;
    end

    assign sck_o   = pin_o[0];
    assign sck_oe  = pin_oe[0];
    assign mosi_o  = pin_o[1];
    assign mosi_oe = pin_oe[1];
    assign miso_o  = pin_o[2];
    assign miso_oe = pin_oe[2];
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_mask_i,
    input logic irq_o,
    input logic done_flag,
    input logic fault_flag,
    input logic busy,
    input logic spi_en,
    input logic od,
    input logic m_mode,
    input logic cpol,
    input logic sck_raw,
    input logic ss_gp,
    input logic sck_o,
    input logic sck_oe,
    input logic mosi_o,
    input logic mosi_oe,
    input logic miso_o,
    input logic miso_oe
);
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_i |-> !irq_o);

    a_r11_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> !(sck_oe || mosi_oe || miso_oe));

    a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> !(sck_oe || mosi_oe || miso_oe));

    a_r12_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        od |-> !((sck_oe && sck_o) || (mosi_oe && mosi_o) || (miso_oe && miso_o)));

    a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (m_mode && !busy) |-> (sck_raw == cpol));

    a_r2_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));

    a_r10_gp_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_gp && !fault_flag) |=> !fault_flag);
endmodule

bind spi_port_ctrl spi_port_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_mask_i(irq_mask_i),
    .irq_o     (irq_o),
    .done_flag (done_flag),
    .fault_flag(fault_flag),
    .busy      (state != spi_port_pkg::ST_IDLE),
    .spi_en    (ctrl.spi_en),
    .od        (ctrl.wired_or),
    .m_mode    (m_mode),
    .cpol      (ctrl.cpol),
    .sck_raw   (sck_lvl ^ ctrl.cpol),
    .ss_gp     (ss_gp_o),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mosi_o    (mosi_o),
    .mosi_oe   (mosi_oe),
    .miso_o    (miso_o),
    .miso_oe   (miso_oe)
);

// File: tb/tb_spi_port_ctrl.sv
module tb_spi_port_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_mask_i = 1'b1, irq_o;
    logic       ss_dir_i = 1'b0, ss_n_i = 1'b1, sck_i = 1'b0;
    logic       sck_o, sck_oe, mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe, pins_spi_o, ss_gp_o;

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    bit         mon_en = 0;
    logic       cur_cpol = 0, cur_cpha = 0;
    logic       sck_prev = 0;
    logic [7:0] mon_byte = 0;
    int         mon_bits = 0;
    logic [7:0] slv_sh = 0;
    logic       bench_miso = 0;

    wire sck_line  = sck_oe  ? sck_o  : 1'b1;
    wire mosi_line = mosi_oe ? mosi_o : 1'b1;
    wire miso_line = miso_oe ? miso_o : 1'b1;
    assign miso_i = bench_miso;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_mask_i(irq_mask_i), .irq_o(irq_o), .ss_dir_i(ss_dir_i),
        .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .pins_spi_o(pins_spi_o), .ss_gp_o(ss_gp_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // monitor: rebuilds master-out bytes, plays the remote slave on master-in
    always @(negedge clk) begin
        logic now_v, lead_ev;
        now_v = sck_line;
        if (mon_en && now_v != sck_prev) begin
            lead_ev = (now_v != cur_cpol);
            if (cur_cpha ? !lead_ev : lead_ev) begin
                mon_byte = {mon_byte[6:0], mosi_line};
                mon_bits++;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) chk("R2 unexpected frame", mon_byte, 8'hxx);
                    else chk("R2 serial byte", mon_byte, exp_q.pop_front());
                end
            end
            if (cur_cpha && lead_ev) begin
                bench_miso = slv_sh[7];
                slv_sh = slv_sh << 1;
            end else if (!cur_cpha && !lead_ev) begin
                slv_sh = slv_sh << 1;
                bench_miso = slv_sh[7];
            end
        end
        sck_prev = now_v;
    end

    task automatic mxfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] rx);
        int h;
        logic [7:0] d;
        h = (cfg[1:0] == 2'd0) ? 1 : (cfg[1:0] == 2'd1) ? 2 : (cfg[1:0] == 2'd2) ? 8 : 16;
        wr(2'd0, cfg);
        cur_cpol = cfg[3]; cur_cpha = cfg[2];
        @(negedge clk);
        chk("R4 idle clock level", {7'b0, sck_line}, {7'b0, cfg[3]});
        slv_sh = rx; bench_miso = rx[7]; mon_bits = 0;
        exp_q.push_back(tx);
        mon_en = 1;
        wr(2'd2, tx);
        if (cfg[2]) chk("R5 phase1 line before edge", {7'b0, mosi_line}, 8'h00);
        else        chk("R5 phase0 MSB at start", {7'b0, mosi_line}, {7'b0, tx[7]});
        repeat (h) @(negedge clk);
        if (cfg[2]) chk("R5 phase1 MSB after first edge", {7'b0, mosi_line}, {7'b0, tx[7]});
        repeat (15*h - 1) @(negedge clk);
        peek(2'd1, d);
        chk("R3 flag not yet set", d & 8'h80, 8'h00);
        @(negedge clk);
        peek(2'd1, d);
        chk("R3 flag set at 16 half periods", d & 8'h80, 8'h80);
        peek(2'd2, d);
        chk("R2 received byte", d, rx);
        mon_en = 0;
        @(negedge clk);
        chk("R4 clock back at idle", {7'b0, sck_line}, {7'b0, cfg[3]});
        rd(2'd1); rd(2'd2);
        peek(2'd1, d);
        chk("R7 flag cleared by sequence", d & 8'h80, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(2'd0, d); chk("R1 control reset", d, 8'h24);
        peek(2'd1, d); chk("R1 status reset", d, 8'h00);
        chk("R9 no drive after reset", {4'b0, pins_spi_o, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // master frames across rates, polarities and phases
        mxfer(8'h50, 8'hA5, 8'h3C);
        mxfer(8'h55, 8'hB4, 8'h96);
        mxfer(8'h5A, 8'h1E, 8'hE1);
        mxfer(8'h5F, 8'hC3, 8'h5A);

        // R7: data access without prior status read keeps the flag
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h11);
        repeat (20) @(negedge clk);
        rd(2'd2);
        peek(2'd1, d); chk("R7 data read alone keeps flag", d & 8'h80, 8'h80);
        rd(2'd1); rd(2'd2);
        peek(2'd1, d); chk("R7 sequence clears", d & 8'h80, 8'h00);

        // R8: interrupt gating
        wr(2'd0, 8'hD0);
        irq_mask_i = 1'b1;
        wr(2'd2, 8'h22);
        repeat (20) @(negedge clk);
        chk("R8 masked request", {7'b0, irq_o}, 8'h00);
        irq_mask_i = 1'b0;
        #1 chk("R8 unmasked request", {7'b0, irq_o}, 8'h01);
        wr(2'd0, 8'h50);
        chk("R8 enable bit off", {7'b0, irq_o}, 8'h00);
        rd(2'd1); rd(2'd2);
        irq_mask_i = 1'b1;

        // R12: open drain
        wr(2'd0, 8'h70);
        wr(2'd2, 8'h80);
        chk("R12 high bit released", {6'b0, mosi_oe, mosi_o}, 8'h00);
        repeat (20) @(negedge clk);
        rd(2'd1); rd(2'd2);
        wr(2'd2, 8'h00);
        chk("R12 low bit driven", {6'b0, mosi_oe, mosi_o}, 8'h02);
        repeat (20) @(negedge clk);
        rd(2'd1); rd(2'd2);
        wr(2'd0, 8'h50);
        @(negedge clk);
        chk("R12 push-pull clock drive", {6'b0, sck_oe, sck_o}, 8'h02);

        // R9: port disabled
        wr(2'd0, 8'h10);
        @(negedge clk);
        chk("R9 released pins", {4'b0, pins_spi_o, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // R10: select as general-purpose output
        wr(2'd0, 8'h50);
        ss_dir_i = 1'b1; ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        peek(2'd1, d); chk("R10 no fault with gp select", d & 8'h40, 8'h00);
        chk("R10 gp flag", {7'b0, ss_gp_o}, 8'h01);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        ss_dir_i = 1'b0;

        // R11: mode fault
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(2'd1, d); chk("R11 fault flag", d & 8'h40, 8'h40);
        peek(2'd0, d); chk("R11 master bit cleared", d & 8'h10, 8'h00);
        chk("R11 drivers off", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1);
        wr(2'd0, 8'h50);
        peek(2'd1, d); chk("R11 fault cleared", d & 8'h40, 8'h00);

        // R6: slave frame, phase 0
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h3C);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        got = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = 8'hC5 >> i;
            repeat (4) @(negedge clk);
            got = {got[6:0], miso_line};
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            repeat (8) @(negedge clk);
        end
        chk("R6 slave sent byte", got, 8'h3C);
        peek(2'd1, d); chk("R6 slave flag", d & 8'h80, 8'h80);
        peek(2'd2, d); chk("R6 slave received byte", d, 8'hC5);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 slave released master-in", {7'b0, miso_oe}, 8'h00);

        chk("R2 all queued frames seen", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule